// File: doc/BRIEF.md
# UART Interrupt Identification Priority Encoder

This block is the interrupt identification logic of a UART. Five interrupt sources are held in their own pending latches: receiver line errors, received data available, receive character timeout (buffered mode only), transmit holding register empty, and modem input change. Each source is masked by an enable bit. Every cycle the block picks the highest-priority enabled pending source. That choice is registered as the reported state, and the state drives a 4-bit identification code and a single interrupt request line.

Each source is cleared by the bus access that services it. The bus side is reduced to read and write strobes with a register select; the FIFO, the shifters, the baud generator and the enable register sit outside the block. They feed it with level and pulse inputs.

The reported state machine has six states: IDLE, LINE, RXDATA, TIMEOUT, TXEMPTY and MODEM. On every clock it moves from any state to the state of the highest-priority enabled pending source, or to IDLE when none is pending. A new event therefore appears on the identification code two rising edges after it is sampled: one edge sets the latch and the next updates the state. A clear also takes two edges to show.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, `int_id` reads 4'b0001 and `irq` is 0.
- R2: A pulse on any bit of `line_err` latches the line source. When `src_en[2]` is set, the code is 4'b0110, which is the highest priority. A read with select 5 clears it.
- R3: A rising edge of `rx_hit` latches received data. When `src_en[0]` is set, the code is 4'b0100. A read with select 0 clears it.
- R4: In buffered mode (`fifo_mode`=1), received data is also cleared when `rx_hit` is low, with no read.
- R5: A pulse on `rx_tmo` latches the timeout source only in buffered mode. It is reported as 4'b1100 under `src_en[0]`, ranks below received data, and a read with select 0 clears it. In character mode the pulse is ignored and bit 3 of `int_id` reads 0.
- R6: A rising edge of `thr_empty` latches transmit-empty. When `src_en[1]` is set, the code is 4'b0010. It is cleared by a write with select 0, or by a read with select 2 while 4'b0010 is the reported code. A select-2 read while another code is reported leaves it pending.
- R7: A pulse on any bit of `modem_delta` latches the modem source. When `src_en[3]` is set, the code is 4'b0000, the lowest priority. A read with select 6 clears it.
- R8: A disabled source is not reported, but its latch is kept, so setting its enable bit later reports it.
- R9: Setting `src_en[1]` while `thr_empty` is high sets the transmit-empty latch, even with no new edge on `thr_empty`.
- R10: The order is line > received data > timeout > transmit-empty > modem. `irq` is 1 exactly when `int_id[0]` is 0.
- R11: When a set event and its clearing access fall in the same cycle, the set wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 = buffered mode, 0 = character mode |
| src_en | input | 4 | Enables: [0] rx data and timeout, [1] tx empty, [2] line, [3] modem |
| line_err | input | ERR_W | Pulses for overrun, parity, framing, break |
| rx_hit | input | 1 | Data ready (character mode) or occupancy at/above trigger (buffered) |
| rx_tmo | input | 1 | Pulse: receive character timeout elapsed |
| thr_empty | input | 1 | Level: transmit holding register empty |
| modem_delta | input | MDM_W | Pulses for changes on CTS, DSR, RI, DCD |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_sel | input | SEL_W | Register select |
| int_id | output | 4 | Identification code, bit 0 active-low pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench raises every source at once and then services them one at a time. A wrong priority order would show up as an out-of-order code during this walk. It also checks that reading the identification register clears transmit-empty only while that code is the one reported. A design that cleared it on any such read would lose the transmit interrupt that sits behind a line error. It checks that an enable bit set over a transmit holding register that is already empty raises the interrupt; an edge-only design would never interrupt in that case. It also checks that a set event coinciding with its clearing access is kept, since dropping it would silently lose an error event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC   = 5;
    localparam int IX_LINE = 0;
    localparam int IX_RXD  = 1;
    localparam int IX_TMO  = 2;
    localparam int IX_TXE  = 3;
    localparam int IX_MDM  = 4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LINE    = 3'd1,
        ST_RXDATA  = 3'd2,
        ST_TIMEOUT = 3'd3,
        ST_TXEMPTY = 3'd4,
        ST_MODEM   = 3'd5
    } rpt_e;

    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_LINE = 4'b0110;
    localparam logic [3:0] ID_RXD  = 4'b0100;
    localparam logic [3:0] ID_TMO  = 4'b1100;
    localparam logic [3:0] ID_TXE  = 4'b0010;
    localparam logic [3:0] ID_MDM  = 4'b0000;
endpackage

// File: rtl/uart_irq_src_latch.sv
module uart_irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R11
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    // R11
    latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    output rpt_e            pick_o
);
    always_comb begin
        if      (pend_i[IX_LINE]) pick_o = ST_LINE;
        else if (pend_i[IX_RXD])  pick_o = ST_RXDATA;
        else if (pend_i[IX_TMO])  pick_o = ST_TIMEOUT;
        else if (pend_i[IX_TXE])  pick_o = ST_TXEMPTY;
        else if (pend_i[IX_MDM])  pick_o = ST_MODEM;
        else                      pick_o = ST_IDLE;
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int ERR_W     = 4,
    parameter int MDM_W     = 4,
    parameter int SEL_W     = 3,
    parameter int SEL_DATA  = 0,
    parameter int SEL_ID    = 2,
    parameter int SEL_LINE  = 5,
    parameter int SEL_MODEM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [3:0]       src_en,
    input  logic [ERR_W-1:0] line_err,
    input  logic             rx_hit,
    input  logic             rx_tmo,
    input  logic             thr_empty,
    input  logic [MDM_W-1:0] modem_delta,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    output logic [3:0]       int_id,
    output logic             irq
);
    localparam logic [SEL_W-1:0] S_DATA  = SEL_W'(SEL_DATA);
    localparam logic [SEL_W-1:0] S_ID    = SEL_W'(SEL_ID);
    localparam logic [SEL_W-1:0] S_LINE  = SEL_W'(SEL_LINE);
    localparam logic [SEL_W-1:0] S_MODEM = SEL_W'(SEL_MODEM);

    rpt_e st, st_nxt;

    logic rd_data, rd_id, rd_line, rd_modem, wr_data;
    assign rd_data  = bus_rd && (bus_sel == S_DATA);
    assign rd_id    = bus_rd && (bus_sel == S_ID);
    assign rd_line  = bus_rd && (bus_sel == S_LINE);
    assign rd_modem = bus_rd && (bus_sel == S_MODEM);
    assign wr_data  = bus_wr && (bus_sel == S_DATA);

    logic rx_prev, txe_prev, en_txe_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev     <= 1'b0;
            txe_prev    <= 1'b0;
            en_txe_prev <= 1'b0;
        end else begin
            rx_prev     <= rx_hit;
            txe_prev    <= thr_empty;
            en_txe_prev <= src_en[1];
        end
    end

    logic [NSRC-1:0] set_v, clr_v, lat_v, en_v, pend_v;

    always_comb begin
        set_v[IX_LINE] = |line_err;
        clr_v[IX_LINE] = rd_line;
        set_v[IX_RXD]  = rx_hit && !rx_prev;
        clr_v[IX_RXD]  = rd_data || (fifo_mode && !rx_hit);
        set_v[IX_TMO]  = rx_tmo && fifo_mode;
        clr_v[IX_TMO]  = rd_data || !fifo_mode;
        set_v[IX_TXE]  = thr_empty && (!txe_prev || (src_en[1] && !en_txe_prev));
        clr_v[IX_TXE]  = wr_data || (rd_id && st == ST_TXEMPTY);
        set_v[IX_MDM]  = |modem_delta;
        clr_v[IX_MDM]  = rd_modem;
        en_v[IX_LINE]  = src_en[2];
        en_v[IX_RXD]   = src_en[0];
        en_v[IX_TMO]   = src_en[0] && fifo_mode;
        en_v[IX_TXE]   = src_en[1];
        en_v[IX_MDM]   = src_en[3];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uart_irq_src_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (lat_v[g])
        );
    end

    assign pend_v = lat_v & en_v;

    uart_irq_arbiter u_arb (
        .pend_i (pend_v),
        .pick_o (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        int_id = ID_NONE;
        irq    = 1'b1;
        unique case (st)
            ST_IDLE:    begin int_id = ID_NONE; irq = 1'b0; end
            ST_LINE:    int_id = ID_LINE;
            ST_RXDATA:  int_id = ID_RXD;
            ST_TIMEOUT: int_id = fifo_mode ? ID_TMO : (ID_TMO & 4'b0111);
            ST_TXEMPTY: int_id = ID_TXE;
            ST_MODEM:   int_id = ID_MDM;
            default:    begin int_id = ID_NONE; irq = 1'b0; end
        endcase
    end

    // R2
    line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v[IX_LINE] |=> (int_id == ID_LINE));
    // R10
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v == '0) |=> !irq);
    // R6
    txe_id_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_id && st == ST_TXEMPTY && !set_v[IX_TXE]) |=> !lat_v[IX_TXE]);
    // R9
    txe_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && src_en[1] && !en_txe_prev) |=> lat_v[IX_TXE]);
endmodule

// File: tb/uart_irq_id_tb.sv
`timescale 1ns/1ps
module uart_irq_id_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [3:0] src_en = 4'b0;
    logic [3:0] line_err = 4'b0;
    logic       rx_hit = 1'b0;
    logic       rx_tmo = 1'b0;
    logic       thr_empty = 1'b0;
    logic [3:0] modem_delta = 4'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_sel = 3'd0;
    logic [3:0] int_id;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_id u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .src_en(src_en),
        .line_err(line_err), .rx_hit(rx_hit), .rx_tmo(rx_tmo),
        .thr_empty(thr_empty), .modem_delta(modem_delta),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .int_id(int_id), .irq(irq)
    );

    task automatic chk(input logic [3:0] exp_id, input string tag);
        total++;
        if (int_id !== exp_id || irq !== !exp_id[0]) begin
            bad++;
            $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
                     tag, int_id, irq, exp_id, !exp_id[0]);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] s);
        bus_sel = s; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] s);
        bus_sel = s; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(4'b0001, "R1 reset");
    endtask

    task automatic t_line();
        src_en = 4'b0100;
        line_err = 4'b0010; @(negedge clk); line_err = 4'b0;
        settle(); chk(4'b0110, "R2 line raise");
        rd(3'd5); settle(); chk(4'b0001, "R2 line clear");
        line_err = 4'b1000; @(negedge clk); line_err = 4'b0;
        settle(); chk(4'b0110, "R2 break bit");
        rd(3'd5); settle();
    endtask

    task automatic t_rx();
        fifo_mode = 1'b0; src_en = 4'b0001;
        rx_hit = 1'b1; settle(); chk(4'b0100, "R3 rx raise");
        rd(3'd0); rx_hit = 1'b0; settle(); chk(4'b0001, "R3 rx read clear");
        fifo_mode = 1'b1;
        rx_hit = 1'b1; settle(); chk(4'b0100, "R4 fifo rx raise");
        rx_hit = 1'b0; settle(); chk(4'b0001, "R4 below trigger clear");
    endtask

    task automatic t_timeout();
        fifo_mode = 1'b1; src_en = 4'b0001;
        rx_tmo = 1'b1; @(negedge clk); rx_tmo = 1'b0;
        settle(); chk(4'b1100, "R5 timeout raise");
        rx_hit = 1'b1; settle(); chk(4'b0100, "R5 rx over timeout");
        rd(3'd0); rx_hit = 1'b0; settle(); chk(4'b0001, "R5 read clears");
        fifo_mode = 1'b0;
        rx_tmo = 1'b1; @(negedge clk); rx_tmo = 1'b0;
        settle(); chk(4'b0001, "R5 ignored in char mode");
    endtask

    task automatic t_txe();
        fifo_mode = 1'b0; src_en = 4'b0010;
        thr_empty = 1'b1; settle(); chk(4'b0010, "R6 txe raise");
        rd(3'd2); settle(); chk(4'b0001, "R6 id read clear");
        thr_empty = 1'b0; @(negedge clk);
        thr_empty = 1'b1; settle(); chk(4'b0010, "R6 txe again");
        wr(3'd0); thr_empty = 1'b0; settle(); chk(4'b0001, "R6 write clear");
        src_en = 4'b0110;
        thr_empty = 1'b1; line_err = 4'b0001; @(negedge clk); line_err = 4'b0;
        settle(); chk(4'b0110, "R10 line over txe");
        rd(3'd2); settle(); chk(4'b0110, "R6 id read keeps line");
        rd(3'd5); settle(); chk(4'b0010, "R6 txe survives id read");
        wr(3'd0); thr_empty = 1'b0; settle();
    endtask

    task automatic t_modem();
        src_en = 4'b1000;
        modem_delta = 4'b0100; @(negedge clk); modem_delta = 4'b0;
        settle(); chk(4'b0000, "R7 modem raise");
        rd(3'd6); settle(); chk(4'b0001, "R7 modem clear");
    endtask

    task automatic t_enable();
        src_en = 4'b0000;
        line_err = 4'b0100; @(negedge clk); line_err = 4'b0;
        settle(); chk(4'b0001, "R8 disabled hidden");
        src_en = 4'b0100; settle(); chk(4'b0110, "R8 enable reveals");
        rd(3'd5); settle();
    endtask

    task automatic t_txe_en();
        src_en = 4'b0010; thr_empty = 1'b1; settle();
        rd(3'd2); settle(); chk(4'b0001, "R9 cleared first");
        src_en = 4'b0000; @(negedge clk);
        src_en = 4'b0010; settle(); chk(4'b0010, "R9 enable over empty");
        wr(3'd0); thr_empty = 1'b0; settle();
    endtask

    task automatic t_priority();
        fifo_mode = 1'b1; src_en = 4'b1111;
        line_err = 4'b0001; modem_delta = 4'b0001; rx_tmo = 1'b1;
        rx_hit = 1'b1; thr_empty = 1'b1;
        @(negedge clk);
        line_err = 4'b0; modem_delta = 4'b0; rx_tmo = 1'b0;
        settle(); chk(4'b0110, "R10 all pending line");
        rd(3'd5); settle(); chk(4'b0100, "R10 then rx");
        rx_hit = 1'b0; settle(); chk(4'b1100, "R10 then timeout");
        rd(3'd0); settle(); chk(4'b0010, "R10 then txe");
        rd(3'd2); settle(); chk(4'b0000, "R10 then modem");
        rd(3'd6); settle(); chk(4'b0001, "R10 all serviced");
        wr(3'd0); thr_empty = 1'b0; fifo_mode = 1'b0; settle();
    endtask

    task automatic t_setwins();
        src_en = 4'b0100;
        line_err = 4'b0010; bus_sel = 3'd5; bus_rd = 1'b1;
        @(negedge clk);
        line_err = 4'b0; bus_rd = 1'b0;
        settle(); chk(4'b0110, "R11 set beats clear");
        rd(3'd5); settle(); chk(4'b0001, "R11 later clear");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_line();
        t_rx();
        t_timeout();
        t_txe();
        t_modem();
        t_enable();
        t_txe_en();
        t_priority();
        t_setwins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule